// File: doc/BRIEF.md
# Linked-Descriptor DMA Control Sequencer

This block is the control core of a single-channel peripheral DMA. Software programs one 64-bit command register, written as two 32-bit halves: the low half is only staged, and the command takes effect when the high half is written. The low five bits are control flags. The remaining bits give the 32-byte aligned address of the first descriptor. On a start command the sequencer reads a twelve-word descriptor one word at a time through a simple read port. It then passes the transfer fields to an external data mover and waits for that mover to report completion.

After each completed descriptor, the sequencer either follows the next pointer or goes idle. The next pointer carries a valid flag in its lowest bit. A last pointer that leads back to the first descriptor makes the chain a ring that runs until stopped. Each descriptor can request a one-clock interrupt pulse on completion. The pulse also sets a sticky flag that software clears by writing 1 to it. A stop command parks the channel at the next word boundary and keeps its position, and a later start resumes from there.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, `busy`, `rd_req`, `mv_start` and `irq` are 0, and both halves of the register read back as 0.
- R2: A write to the low half (`cfg_hi`=0) only stages the value. The read-back value stays the same and no command starts until the high half is written. On that high write the staged value becomes visible on the low read-back.
- R3: A start command (low bit 3 = 1, bit 4 = 0) from idle fetches twelve words. The first word address is the committed register value with bits [4:0] forced to zero. Each following word address is 4 higher. `rd_addr` is held stable with `rd_req` high until `rd_valid` answers it. With a memory that answers each word on the second cycle, `mv_start` is high 24 cycles after the committing edge.
- R4: `mv_start` is a single-cycle pulse. While it is high, the outputs show the fetched descriptor fields: mem address (words 1 and 9), device address (word 2), length (word 3), step length (word 4), step count (word 5) and direction (`mv_to_dev` = command word 6 bit 12). `mv_uncached` shows register bit 1.
- R5: Register bit 0 enables 64-bit addressing. When it is clear, the register high half, the next-high word (8) and the mem-high word (9) are treated as zero. When it is set, they supply address bits [63:32]. Register bit 31 of the high half is the interrupt flag, so address bit 63 cannot be set from the register.
- R6: After `mv_done`, when word 0 bit 0 is 1, the next descriptor is fetched from {word 8, word 0 [31:1], 0}. When that bit is 0, the sequencer returns to idle.
- R7: A chain whose last pointer leads back to its first descriptor repeats its descriptors in order without end until stopped.
- R8: When command word bit 1 is set, `irq` is high for exactly one cycle, on the cycle after the `mv_done` cycle. No pulse is produced when that bit is clear.
- R9: Each `irq` pulse sets bit 31 of the high read-back. Writing the high half with bit 31 = 1 clears it. A pulse in the same cycle wins over the clear.
- R10: A stop (low bit 4 = 1) during a fetch takes effect when the outstanding word completes, and the channel goes idle. A following start re-fetches that same descriptor and ignores the register address.
- R11: A stop during a transfer waits for `mv_done`. The interrupt of that descriptor is still produced. The channel then goes idle, and a following start continues with the next descriptor.
- R12: A start while busy has no effect. A stop while idle discards any parked position, so the next start uses the register address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_hi | input | 1 | Selects high half for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the selected half |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 64 | Byte address of the requested word |
| rd_valid | input | 1 | Read answer; completes the request |
| rd_data | input | 32 | Read data |
| mv_start | output | 1 | One-cycle transfer launch |
| mv_mem_addr | output | 64 | Memory address of the transfer |
| mv_dev_addr | output | 32 | Device address |
| mv_len | output | 32 | Length in words |
| mv_step_len | output | 32 | Gap between blocks |
| mv_step_cnt | output | 32 | Block count |
| mv_to_dev | output | 1 | 1: memory to device |
| mv_uncached | output | 1 | Uncached access flag |
| mv_done | input | 1 | Transfer finished |
| irq | output | 1 | One-cycle completion interrupt |
| busy | output | 1 | Sequencer not idle |

## Verification
The committing edge of a start launches the fetch at once. Because the bench memory answers each word on the second cycle, `mv_start` is due 24 cycles after that edge. The bench counts posedges and checks this distance at the negedge where the pulse is first seen. The interrupt is due one edge after the `mv_done` cycle, and the flag is set on that same edge. The bench therefore counts interrupt-high cycles at negedges and reads the flag only after `busy` has fallen. Stop and resume outcomes are checked after `busy` drops plus a settling margin, because a stop waits for a word or transfer boundary.

// File: rtl/dma_seq_pkg.sv
// Shared constants and types of the descriptor-chain sequencer.
// Assumes 32-bit descriptor words and 64-bit byte addresses.
package dma_seq_pkg;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 2 * WORD_W;
    localparam int DESC_WORDS = 12;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int ALIGN_BITS = 5;

    // control flag positions in the low half
    localparam int F_EN64     = 0;
    localparam int F_UNCACHED = 1;
    localparam int F_START    = 3;
    localparam int F_STOP     = 4;
    // sticky interrupt flag position in the high half
    localparam int F_IRQ      = WORD_W - 1;

    // descriptor word positions (fixed by the in-memory layout)
    localparam int W_NXT_LO = 0;
    localparam int W_MEM_LO = 1;
    localparam int W_DEV    = 2;
    localparam int W_LEN    = 3;
    localparam int W_STEP_L = 4;
    localparam int W_STEP_N = 5;
    localparam int W_CMD    = 6;
    localparam int W_NXT_HI = 8;
    localparam int W_MEM_HI = 9;

    localparam int C_IRQ = 1;
    localparam int C_DIR = 12;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_ISSUE, ST_WAIT, ST_NEXT
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] mem_addr;
        logic [WORD_W-1:0] dev_addr;
        logic [WORD_W-1:0] len;
        logic [WORD_W-1:0] step_len;
        logic [WORD_W-1:0] step_cnt;
        logic              to_dev;
        logic              irq_en;
        logic              next_ok;
        logic [ADDR_W-1:0] next_addr;
    } xfer_t;
endpackage

// File: rtl/dma_cfg_reg.sv
// Command register: the low half is staged, and the high-half write commits
// both halves and produces the start/stop command pulses. Holds the sticky
// interrupt flag (write 1 to clear, a set in the same cycle wins).
// Assumes the head address is taken from the committing write itself.
module dma_cfg_reg
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              irq_set,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic [ADDR_W-1:0] cmd_head,
    output logic              en64,
    output logic              uncached,
    output logic              irq_flag
);
    logic [WORD_W-1:0] stage_lo, reg_lo;
    logic [WORD_W-2:0] reg_hi;
    logic              commit;

    assign commit = wr & hi;

    // staging, commit and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_lo <= '0;
            reg_lo   <= '0;
            reg_hi   <= '0;
            irq_flag <= 1'b0;
        end else begin
            if (wr && !hi) stage_lo <= wdata;
            if (commit) begin
                reg_lo <= stage_lo;
                reg_hi <= wdata[WORD_W-2:0];
            end
            irq_flag <= irq_set | (irq_flag & ~(commit & wdata[F_IRQ]));
        end
    end

    // command pulses and head address decoded from the committing write
    always_comb begin
        cmd_stop  = commit & stage_lo[F_STOP];
        cmd_start = commit & stage_lo[F_START] & ~stage_lo[F_STOP];
        cmd_head  = {(stage_lo[F_EN64] ? {1'b0, wdata[WORD_W-2:0]} : {WORD_W{1'b0}}),
                     stage_lo[WORD_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end

    // read-back mux
    assign rdata    = hi ? {irq_flag, reg_hi} : reg_lo;
    assign en64     = reg_lo[F_EN64];
    assign uncached = reg_lo[F_UNCACHED];

    AST_LOW_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hi) |=> $stable(reg_lo)); // R2
endmodule

// File: rtl/dma_desc_fetch.sv
// Descriptor reader: on go, reads DESC_WORDS consecutive words from base,
// one request at a time, and decodes the captured words into transfer
// fields. kill abandons the fetch on the cycle a word completes.
// Assumes go is only given while not active.
module dma_desc_fetch
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    input  logic              kill,
    input  logic              en64,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              word_ack,
    output logic              done,
    output xfer_t             xfer
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DESC_WORDS - 1);

    logic                          active;
    logic [IDX_W-1:0]              idx;
    logic [ADDR_W-1:0]             base_q;
    logic [DESC_WORDS-1:0][WORD_W-1:0] words;

    assign rd_req   = active;
    assign rd_addr  = base_q + ADDR_W'({idx, 2'b00});
    assign word_ack = active & rd_valid;
    assign done     = word_ack & (idx == LAST);

    // word counter and fetch activity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            base_q <= '0;
        end else if (go) begin
            active <= 1'b1;
            idx    <= '0;
            base_q <= base;
        end else if (kill || done) begin
            active <= 1'b0;
        end else if (word_ack) begin
            idx <= idx + 1'b1;
        end
    end

    // capture of each returned word into its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
        end else if (word_ack) begin
            for (int k = 0; k < DESC_WORDS; k++)
                if (idx == IDX_W'(k)) words[k] <= rd_data;
        end
    end

    // field decode; high words count only with 64-bit addressing
    always_comb begin
        xfer.mem_addr  = {(en64 ? words[W_MEM_HI] : {WORD_W{1'b0}}), words[W_MEM_LO]};
        xfer.dev_addr  = words[W_DEV];
        xfer.len       = words[W_LEN];
        xfer.step_len  = words[W_STEP_L];
        xfer.step_cnt  = words[W_STEP_N];
        xfer.to_dev    = words[W_CMD][C_DIR];
        xfer.irq_en    = words[W_CMD][C_IRQ];
        xfer.next_ok   = words[W_NXT_LO][0];
        xfer.next_addr = {(en64 ? words[W_NXT_HI] : {WORD_W{1'b0}}),
                          words[W_NXT_LO][WORD_W-1:1], 1'b0};
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid && idx != LAST) |=>
            (!rd_req || rd_addr == $past(rd_addr) + ADDR_W'(4))); // R3
endmodule

// File: rtl/dma_seq_fsm.sv
// Sequencer state machine: IDLE -> FETCH -> ISSUE -> WAIT -> NEXT.
// Keeps the current descriptor address and a parked flag for resume.
// A stop is honoured at a word boundary in FETCH or after done otherwise.
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic [ADDR_W-1:0] cmd_head,
    input  logic              fetch_ack,
    input  logic              fetch_done,
    input  xfer_t             xfer,
    input  logic              mv_done,
    output logic              fetch_go,
    output logic [ADDR_W-1:0] fetch_base,
    output logic              fetch_kill,
    output logic              mv_start,
    output logic              irq_set,
    output logic              irq,
    output logic              busy
);
    seq_state_e        state, state_n;
    logic [ADDR_W-1:0] cur_q, cur_n;
    logic              parked_q, parked_n;
    logic              stop_q, stop_n;

    // next-state and command decode
    always_comb begin
        state_n    = state;
        cur_n      = cur_q;
        parked_n   = parked_q;
        stop_n     = stop_q | (cmd_stop & (state != ST_IDLE));
        fetch_go   = 1'b0;
        fetch_base = cur_q;
        fetch_kill = 1'b0;
        mv_start   = 1'b0;
        irq_set    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_stop) begin
                    parked_n = 1'b0;
                end else if (cmd_start) begin
                    fetch_go   = 1'b1;
                    fetch_base = parked_q ? cur_q : cmd_head;
                    cur_n      = fetch_base;
                    parked_n   = 1'b0;
                    stop_n     = 1'b0;
                    state_n    = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (fetch_ack && stop_n) begin
                    fetch_kill = 1'b1;
                    parked_n   = 1'b1;
                    stop_n     = 1'b0;
                    state_n    = ST_IDLE;
                end else if (fetch_done) begin
                    state_n = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                mv_start = 1'b1;
                state_n  = ST_WAIT;
            end
            ST_WAIT: begin
                if (mv_done) begin
                    irq_set = xfer.irq_en;
                    state_n = ST_NEXT;
                end
            end
            ST_NEXT: begin
                if (xfer.next_ok) begin
                    cur_n = xfer.next_addr;
                    if (stop_n) begin
                        parked_n = 1'b1;
                        stop_n   = 1'b0;
                        state_n  = ST_IDLE;
                    end else begin
                        fetch_go   = 1'b1;
                        fetch_base = xfer.next_addr;
                        state_n    = ST_FETCH;
                    end
                end else begin
                    parked_n = 1'b0;
                    stop_n   = 1'b0;
                    state_n  = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state, context and interrupt pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_q    <= '0;
            parked_q <= 1'b0;
            stop_q   <= 1'b0;
            irq      <= 1'b0;
        end else begin
            state    <= state_n;
            cur_q    <= cur_n;
            parked_q <= parked_n;
            stop_q   <= stop_n;
            irq      <= irq_set;
        end
    end

    assign busy = (state != ST_IDLE);

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
    AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mv_done)); // R8
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |=> !mv_start); // R4
    AST_STOP_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && fetch_ack && cmd_stop) |=> (state == ST_IDLE)); // R10
endmodule

// File: rtl/dma_chain_seq.sv
// Top of the linked-descriptor DMA control sequencer: command register,
// descriptor reader and state machine. Data movement is external; the
// mover reports completion on mv_done.
module dma_chain_seq
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_hi,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              mv_start,
    output logic [ADDR_W-1:0] mv_mem_addr,
    output logic [WORD_W-1:0] mv_dev_addr,
    output logic [WORD_W-1:0] mv_len,
    output logic [WORD_W-1:0] mv_step_len,
    output logic [WORD_W-1:0] mv_step_cnt,
    output logic              mv_to_dev,
    output logic              mv_uncached,
    input  logic              mv_done,
    output logic              irq,
    output logic              busy
);
    logic              cmd_start, cmd_stop, en64, irq_flag, irq_set;
    logic [ADDR_W-1:0] cmd_head, fetch_base;
    logic              fetch_go, fetch_kill, fetch_ack, fetch_done;
    xfer_t             xfer;

    dma_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .hi(cfg_hi), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .irq_set(irq_set), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .cmd_head(cmd_head), .en64(en64),
        .uncached(mv_uncached), .irq_flag(irq_flag)
    );

    dma_desc_fetch u_fetch (
        .clk(clk), .rst_n(rst_n), .go(fetch_go), .base(fetch_base),
        .kill(fetch_kill), .en64(en64), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .word_ack(fetch_ack),
        .done(fetch_done), .xfer(xfer)
    );

    dma_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_head(cmd_head), .fetch_ack(fetch_ack), .fetch_done(fetch_done),
        .xfer(xfer), .mv_done(mv_done), .fetch_go(fetch_go),
        .fetch_base(fetch_base), .fetch_kill(fetch_kill), .mv_start(mv_start),
        .irq_set(irq_set), .irq(irq), .busy(busy)
    );

    assign mv_mem_addr = xfer.mem_addr;
    assign mv_dev_addr = xfer.dev_addr;
    assign mv_len      = xfer.len;
    assign mv_step_len = xfer.step_len;
    assign mv_step_cnt = xfer.step_cnt;
    assign mv_to_dev   = xfer.to_dev;

    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req); // R10
    AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_flag); // R9
    AST_NO_LAUNCH_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !mv_start); // R4
endmodule

// File: tb/tb_dma_chain_seq.sv
`timescale 1ns/1ps
module tb_dma_chain_seq;
    logic        clk = 0, rst_n = 0;
    logic        cfg_wr = 0, cfg_hi = 0;
    logic [31:0] cfg_wdata = 0, cfg_rdata;
    logic        rd_req, rd_valid = 0;
    logic [63:0] rd_addr;
    logic [31:0] rd_data = 0;
    logic        mv_start, mv_to_dev, mv_uncached, mv_done = 0, irq, busy;
    logic [63:0] mv_mem_addr;
    logic [31:0] mv_dev_addr, mv_len, mv_step_len, mv_step_cnt;

    dma_chain_seq dut (.*);

    always #4 clk = ~clk;

    int errors = 0, checks = 0;
    logic [31:0] mem [0:1023];
    bit   dmask [0:15];
    int   exp_n = 1, exp_first = 0, issue_cnt = 0, exp_irq = 0, irq_cycles = 0;
    int   bad_addr = 0, mv_dly = 2, done_cnt = 0, pc = 0, start_pc = 0;
    bit   exp_en64 = 0, exp_unc = 0, lat_armed = 0, finished = 0;
    logic [31:0] exp_hi = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dlo(int i);
        return 32'(i * 64);
    endfunction

    always @(posedge clk) pc++;

    // memory model: answers a pending request on the next negedge
    always @(negedge clk) begin
        if (rd_req && !rd_valid) begin
            if (rd_addr[63:32] != (exp_en64 ? exp_hi : 32'h0) || rd_addr[31:12] != 0)
                bad_addr++;
            rd_data  = mem[rd_addr[11:2]];
            rd_valid = 1;
        end else begin
            rd_valid = 0;
        end
    end

    // mover model and launch monitor
    always @(negedge clk) begin
        int d;
        logic [63:0] em;
        bit ok;
        if (irq) irq_cycles++;
        mv_done = 0;
        if (done_cnt > 0) begin
            done_cnt--;
            if (done_cnt == 0) mv_done = 1;
        end
        if (mv_start) begin
            d  = (exp_first + issue_cnt) % exp_n;
            em = {(exp_en64 ? 32'h70 + 32'(d) : 32'h0), 32'h1000_0000 + 32'(d * 256)};
            ok = mv_mem_addr == em && mv_dev_addr == 32'hBEEF_0000 + 32'(d) &&
                 mv_len == 32'(16 + d) && mv_step_len == 32'(2 * d) &&
                 mv_step_cnt == 32'(1 + d) && mv_to_dev == d[0] &&
                 mv_uncached == exp_unc;
            check(ok, "R4", $sformatf("fields of descriptor %0d (mem addr shown)", d),
                  mv_mem_addr, em);
            if (lat_armed) begin
                check(pc - start_pc == 24, "R3", "cycles to launch", pc - start_pc, 24);
                lat_armed = 0;
            end
            exp_irq += dmask[d];
            issue_cnt++;
            done_cnt = mv_dly;
        end
    end

    task automatic build(int n, bit ring, logic [31:0] hi);
        for (int i = 0; i < n; i++) begin
            int b = i * 16;
            if (i < n - 1)  mem[b] = dlo(i + 1) | 1;
            else            mem[b] = ring ? (dlo(0) | 1) : dlo(0);
            mem[b+1]  = 32'h1000_0000 + 32'(i * 256);
            mem[b+2]  = 32'hBEEF_0000 + 32'(i);
            mem[b+3]  = 32'(16 + i);
            mem[b+4]  = 32'(2 * i);
            mem[b+5]  = 32'(1 + i);
            mem[b+6]  = (32'(dmask[i]) << 1) | (32'(i & 1) << 12);
            mem[b+7]  = 0;
            mem[b+8]  = hi;
            mem[b+9]  = 32'h70 + 32'(i);
            mem[b+10] = 32'hDEAD;
            mem[b+11] = 32'hDEAD;
        end
    endtask

    task automatic wr(bit hi, logic [31:0] data, bit arm);
        @(negedge clk);
        cfg_wr = 1; cfg_hi = hi; cfg_wdata = data;
        if (arm) begin start_pc = pc; lat_armed = 1; end
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic rd(bit hi, output logic [31:0] v);
        @(negedge clk);
        cfg_hi = hi;
        #1 v = cfg_rdata;
    endtask

    function automatic logic [31:0] flags();
        return {30'h0, exp_unc, exp_en64};
    endfunction

    task automatic start_run(logic [31:0] lo, bit arm);
        wr(0, lo | flags() | 32'h8, 0);
        wr(1, exp_hi, arm);
    endtask

    task automatic stop_cmd();
        wr(0, flags() | 32'h10, 0);
        wr(1, exp_hi, 0);
    endtask

    task automatic wait_idle(string req);
        int c = 0;
        while (busy && c < 5000) begin @(negedge clk); c++; end
        if (busy) check(0, req, "timeout waiting for idle", 1, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_issues(int k, string req);
        int c = 0;
        while (issue_cnt < k && c < 5000) begin @(negedge clk); c++; end
        if (issue_cnt < k) check(0, req, "timeout waiting for launch", issue_cnt, k);
    endtask

    task automatic new_run(int n, int first);
        exp_n = n; exp_first = first; issue_cnt = 0; exp_irq = 0;
        irq_cycles = 0; bad_addr = 0;
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 1024; i++) mem[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !rd_req && !mv_start && !irq, "R1", "idle outputs after reset",
              {busy, rd_req, mv_start, irq}, 0);
        rd(0, v); check(v == 0, "R1", "low read-back after reset", v, 0);
        rd(1, v); check(v == 0, "R1", "high read-back after reset", v, 0);

        // R2: low write alone stages only
        wr(0, 32'h8, 0);
        repeat (5) @(negedge clk);
        check(!busy && !rd_req, "R2", "no start from low write", {busy, rd_req}, 0);
        rd(0, v); check(v == 0, "R2", "low read-back unchanged", v, 0);

        // sweep: address mode x chain length
        for (int e = 0; e < 2; e++) begin
            for (int n = 1; n <= 4; n++) begin
                for (int i = 0; i < n; i++) dmask[i] = ((i + n + e) % 2) == 0;
                exp_en64 = e[0]; exp_unc = ~e[0]; exp_hi = 32'hA5 + 32'(n);
                build(n, 0, exp_hi);
                new_run(n, 0);
                start_run(dlo(0) | 32'h4, 1);
                wait_idle("R6");
                check(issue_cnt == n, "R6", "descriptors run before chain end", issue_cnt, n);
                check(irq_cycles == exp_irq, "R8", "interrupt cycles", irq_cycles, exp_irq);
                check(bad_addr == 0, "R5", "fetch address high part/range errors", bad_addr, 0);
                rd(0, v);
                check(v == (dlo(0) | 32'h4 | flags() | 32'h8), "R2", "committed low read-back",
                      v, dlo(0) | 32'h4 | flags() | 32'h8);
                rd(1, v);
                check(v[31] == (exp_irq > 0), "R9", "interrupt flag set", v[31], exp_irq > 0);
                wr(0, flags(), 0);
                wr(1, 32'h8000_0000 | exp_hi, 0);
                rd(1, v);
                check(v[31] == 0, "R9", "interrupt flag cleared by write 1", v[31], 0);
            end
        end

        // R7: ring of three
        exp_en64 = 0; exp_unc = 0; exp_hi = 32'h3;
        for (int i = 0; i < 3; i++) dmask[i] = 1;
        build(3, 1, exp_hi); new_run(3, 0); mv_dly = 2;
        start_run(dlo(0), 0);
        wait_issues(7, "R7");
        stop_cmd();
        wait_idle("R7");
        check(issue_cnt >= 7, "R7", "ring keeps cycling", issue_cnt, 7);
        check(irq_cycles == exp_irq, "R8", "ring interrupt cycles", irq_cycles, exp_irq);
        stop_cmd();

        // R10: stop during fetch, then resume from parked descriptor
        for (int i = 0; i < 3; i++) dmask[i] = 0;
        build(2, 0, exp_hi); new_run(2, 0);
        start_run(dlo(0), 0);
        repeat (3) @(negedge clk);
        stop_cmd();
        wait_idle("R10");
        check(issue_cnt == 0 && !rd_req, "R10", "stop in fetch parks with no launch",
              issue_cnt, 0);
        start_run(dlo(1), 0);
        wait_idle("R10");
        check(issue_cnt == 2, "R10", "resume re-fetches parked descriptor", issue_cnt, 2);

        // R11: stop during transfer
        dmask[0] = 1; dmask[1] = 0; dmask[2] = 1;
        build(3, 0, exp_hi); new_run(3, 0); mv_dly = 20;
        start_run(dlo(0), 0);
        wait_issues(1, "R11");
        stop_cmd();
        wait_idle("R11");
        check(issue_cnt == 1 && irq_cycles == 1, "R11", "stop after done, irq kept",
              {issue_cnt, irq_cycles}, {32'd1, 32'd1});
        start_run(dlo(2), 0);
        wait_idle("R11");
        check(issue_cnt == 3, "R11", "resume continues with next", issue_cnt, 3);
        check(irq_cycles == 2, "R8", "interrupts across resume", irq_cycles, 2);

        // R12: start while busy ignored
        for (int i = 0; i < 3; i++) dmask[i] = 0;
        build(2, 0, exp_hi); new_run(2, 0);
        start_run(dlo(0), 0);
        wait_issues(1, "R12");
        start_run(dlo(1), 0);
        wait_idle("R12");
        check(issue_cnt == 2, "R12", "start while busy has no effect", issue_cnt, 2);

        // R12: stop while idle discards parked position
        build(3, 0, exp_hi); new_run(3, 0); mv_dly = 2;
        start_run(dlo(0), 0);
        repeat (3) @(negedge clk);
        stop_cmd();
        wait_idle("R12");
        stop_cmd();
        new_run(3, 1);
        start_run(dlo(1), 0);
        wait_idle("R12");
        check(issue_cnt == 2, "R12", "fresh start after idle stop", issue_cnt, 2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule